// File: doc/BRIEF.md
# Asynchronous Memory Bank Controller

This controller runs one read or one write at a time on an external asynchronous memory bank. An internal bus presents a request. The request carries a word address, byte enables, write data and a direction, and it is qualified by a valid strobe. The controller then drives the bank's select, address, byte enables, data, output enable and read and write strobes through three timed phases: setup, access and hold. The length of each phase is taken in bus clock cycles from a configuration word. That word is captured when the request is accepted.

A slow device can hold off completion through a ready input. Ready first passes through a two-flop synchronizer. When the programmed access length is two cycles or more and the synchronized ready is low in the final programmed access cycle, the access phase repeats one cycle at a time until ready is seen. For reads, the data bus is captured in the cycle that ends the access phase. A one-cycle done pulse follows the last cycle of the access. All pin-side controls are active high.

Top module: `async_bank_ctrl`

## Requirements
- R1: After reset, `done` is low and `mem_sel`, `mem_oe`, `mem_rd`, `mem_wr` and `mem_dout_en` are low, and `mem_addr`, `mem_be` and `mem_dout` are zero.
- R2: An accepted access keeps `mem_sel` high for S cycles of setup, then A' access cycles with A' = max(1, A), then H hold cycles. With S=2, A=4, H=1 and ready high, it lasts exactly 7 cycles.
- R3: A setup or hold count of zero skips that phase, and an access count of zero behaves as one.
- R4: On a read, `mem_rd` and `mem_oe` are high exactly during the access phase, including any extension. `mem_wr` and `mem_dout_en` stay low.
- R5: On a write, `mem_wr` is high exactly during the access phase. `mem_dout_en` is high and `mem_dout` carries the write data in every cycle in which `mem_sel` is high. `mem_rd` stays low.
- R6: `mem_addr` and `mem_be` hold the accepted request values, unchanged, in every cycle in which `mem_sel` is high, and are zero when it is low.
- R7: `mem_ready` passes through two register stages. If A' ≥ 2 and the synchronized ready is low in the last access cycle, the access phase is extended by one cycle at a time. Ready raised in the k-th access cycle (k ≥ A'-2) gives an access phase of k+2 cycles.
- R8: With A' = 1, `mem_ready` is ignored and the access phase lasts one cycle.
- R9: A read loads `rdata` from `mem_din` as sampled in the final access cycle. `rdata` keeps that value through later writes.
- R10: `done` is high for exactly one cycle, in the cycle after the last `mem_sel` cycle. A request raised while an access is in flight is dropped.
- R11: Changing the configuration inputs during an access does not change that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | 4 | Setup cycles |
| cfg_access | input | 4 | Access cycles (0 acts as 1) |
| cfg_hold | input | 4 | Hold cycles |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address (byte address bits 25..2) |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read data |
| mem_sel | output | 1 | Bank select |
| mem_addr | output | 24 | Word address to the bank |
| mem_be | output | 4 | Byte enables to the bank |
| mem_oe | output | 1 | Output enable |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_dout | output | 32 | Write data to the bank |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 32 | Data from the bank |
| mem_ready | input | 1 | Ready from the bank |

## Verification
The hardest case to reach from the ports is an extension of a known length. The synchronizer delays ready by two cycles, so the wait must begin before the request and the release must be timed against the access cycles already seen. The stimulus pulls ready low a few cycles ahead of the request. It counts strobe cycles at the falling clock edge and raises ready in a chosen access cycle. At that same moment it changes `mem_din`, which shows that only the value present in the final cycle is captured. A request and a configuration change injected during a running access show that both are dropped.

// File: rtl/async_bank_ctrl.sv
module async_bank_ctrl #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int BW = DW / 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_access,
  input  logic [CW-1:0] cfg_hold,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          mem_sel,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_be,
  output logic          mem_oe,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din,
  input  logic          mem_ready
);

  typedef enum logic [1:0] {IDLE, SETUP, ACC, HOLD} state_t;

  state_t        st;
  logic [CW-1:0] cnt, acc_q, hold_q;
  logic          wr_q, rdy_m, rdy_s;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wd_q;

  wire [CW-1:0] acc_in  = (cfg_access == '0) ? CW'(1) : cfg_access;
  wire          busy    = (st != IDLE);
  wire          last    = (cnt == '0);
  wire          use_rdy = (acc_q > CW'(1));
  wire          acc_end = (st == ACC) && last && (!use_rdy || rdy_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy_m <= 1'b0;
      rdy_s <= 1'b0;
    end else begin
      rdy_m <= mem_ready;
      rdy_s <= rdy_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      acc_q  <= CW'(1);
      hold_q <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        IDLE: if (req_valid) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          be_q   <= req_be;
          wd_q   <= req_wdata;
          acc_q  <= acc_in;
          hold_q <= cfg_hold;
          if (cfg_setup != '0) begin
            st  <= SETUP;
            cnt <= cfg_setup - 1'b1;
          end else begin
            st  <= ACC;
            cnt <= acc_in - 1'b1;
          end
        end
        SETUP: if (last) begin
          st  <= ACC;
          cnt <= acc_q - 1'b1;
        end else cnt <= cnt - 1'b1;
        ACC: if (!last) cnt <= cnt - 1'b1;
          else if (acc_end) begin
            if (!wr_q) rdata <= mem_din;
            if (hold_q != '0) begin
              st  <= HOLD;
              cnt <= hold_q - 1'b1;
            end else begin
              st   <= IDLE;
              done <= 1'b1;
            end
          end
        HOLD: if (last) begin
          st   <= IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end

  assign mem_sel     = busy;
  assign mem_addr    = busy ? addr_q : '0;
  assign mem_be      = busy ? be_q : '0;
  assign mem_rd      = (st == ACC) && !wr_q;
  assign mem_oe      = mem_rd;
  assign mem_wr      = (st == ACC) && wr_q;
  assign mem_dout_en = busy && wr_q;
  assign mem_dout    = mem_dout_en ? wd_q : '0;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_sel) |-> done);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |=> (!mem_sel || ($stable(mem_addr) && $stable(mem_be))));
  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> (mem_dout_en && mem_sel));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R8
  short_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && acc_q == CW'(1)) |=> !(mem_rd || mem_wr));

endmodule

// File: tb/async_bank_ctrl_tb.sv
module async_bank_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_setup = '0, cfg_access = '0, cfg_hold = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0, mem_din = '0;
  logic mem_ready = 1'b1;
  logic done, mem_sel, mem_oe, mem_rd, mem_wr, mem_dout_en;
  logic [31:0] rdata, mem_dout;
  logic [23:0] mem_addr;
  logic [3:0] mem_be;
  int checks = 0, errors = 0;
  int tot, strb, first;

  always #5 clk = ~clk;

  async_bank_ctrl u_dut (.clk, .rst_n, .cfg_setup, .cfg_access, .cfg_hold,
    .req_valid, .req_write, .req_addr, .req_be, .req_wdata, .done, .rdata,
    .mem_sel, .mem_addr, .mem_be, .mem_oe, .mem_rd, .mem_wr, .mem_dout,
    .mem_dout_en, .mem_din, .mem_ready);

  // {write, setup, access, hold, expected total cycles}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 4'd2,  4'd4,  4'd1,  8'd7},
    {1'b1, 4'd0,  4'd1,  4'd0,  8'd1},
    {1'b0, 4'd0,  4'd0,  4'd0,  8'd1},
    {1'b1, 4'd3,  4'd2,  4'd0,  8'd5},
    {1'b0, 4'd1,  4'd3,  4'd2,  8'd6},
    {1'b1, 4'd15, 4'd15, 4'd15, 8'd45},
    {1'b0, 4'd0,  4'd0,  4'd4,  8'd5},
    {1'b0, 4'd5,  4'd1,  4'd0,  8'd6}
  };

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic run(input logic wr, input [3:0] s, a, h, input [23:0] ad,
                     input [3:0] b, input [31:0] wd, input int rdy_at,
                     input [31:0] late_din, input int poke);
    int bad = 0;
    @(negedge clk);
    cfg_setup = s; cfg_access = a; cfg_hold = h;
    req_write = wr; req_addr = ad; req_be = b; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    tot = 0; strb = 0; first = 0;
    while (mem_sel && tot < 200) begin
      tot++;
      if (wr ? mem_wr : mem_rd) begin
        strb++;
        if (first == 0) first = tot;
        if (rdy_at != 0 && strb == rdy_at) begin mem_ready = 1'b1; mem_din = late_din; end
      end
      if (mem_addr !== ad || mem_be !== b) bad |= 1;
      if (mem_oe !== mem_rd) bad |= 2;
      if (wr && (!mem_dout_en || mem_dout !== wd || mem_rd)) bad |= 4;
      if (!wr && (mem_wr || mem_dout_en)) bad |= 8;
      if (done) bad |= 16;
      if (poke != 0 && tot == poke) begin
        req_valid = 1'b1; req_addr = ~ad; cfg_access = 4'd15; cfg_hold = 4'd15; cfg_setup = 4'd15;
      end else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk((bad & 1) == 0, "R6 addr/be held", bad, 0);
    chk((bad & 2) == 0, "R4 oe follows rd", bad, 0);
    chk((bad & 12) == 0, wr ? "R5 write drive" : "R4 read strobes", bad, 0);
    chk(done === 1'b1, "R10 done after last cycle", done, 1);
    @(negedge clk);
    chk(done === 1'b0 && mem_sel === 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({done, mem_sel, mem_oe, mem_rd, mem_wr, mem_dout_en} === 6'b0, "R1 controls idle",
        {done, mem_sel, mem_oe, mem_rd, mem_wr, mem_dout_en}, 0);
    chk(mem_addr === '0 && mem_be === '0 && mem_dout === '0, "R1 buses zero", mem_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VEC[i]) begin
      logic w; logic [3:0] s, a, h; int ex, exa;
      {w, s, a, h} = VEC[i][20:8];
      ex = int'(VEC[i][7:0]);
      exa = (a == 0) ? 1 : int'(a);
      mem_din = {8'hA5, 24'(i * 4099 + 7)};
      run(w, s, a, h, 24'(i * 4099 + 7), 4'(i + 1), 32'hC0DE_0000 + i, 0, 0, 0);
      chk(tot == ex, "R2 total length", tot, ex);
      chk(strb == exa, "R3 access length", strb, exa);
      chk(first == int'(s) + 1, "R3 access start", first, int'(s) + 1);
      if (!w) chk(rdata === {8'hA5, 24'(i * 4099 + 7)}, "R9 read data", rdata, {8'hA5, 24'(i * 4099 + 7)});
      chk(mem_addr === '0 && mem_be === '0, "R6 idle zero", mem_addr, 0);
    end

    // R7 extension: ready raised in access cycle 5 of 4 programmed -> 7 access cycles
    mem_ready = 1'b0; mem_din = 32'h1111_1111;
    repeat (3) @(negedge clk);
    run(1'b0, 4'd2, 4'd4, 4'd1, 24'h00ABCD, 4'hF, '0, 5, 32'h7777_2222, 0);
    chk(strb == 7, "R7 stretched access", strb, 7);
    chk(tot == 10, "R7 stretched total", tot, 10);
    chk(rdata === 32'h7777_2222, "R9 data from final cycle", rdata, 32'h7777_2222);

    // R7 boundary: access 2, ready in cycle 2 -> 4 cycles
    mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    run(1'b0, 4'd0, 4'd2, 4'd0, 24'h000123, 4'h3, '0, 2, 32'h3333_4444, 0);
    chk(strb == 4, "R7 two-cycle access stretched", strb, 4);

    // R8 ready low ignored for access 1 and 0
    mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    run(1'b1, 4'd1, 4'd1, 4'd1, 24'h0000AA, 4'h1, 32'hFEED_BEEF, 0, '0, 0);
    chk(strb == 1 && tot == 3, "R8 ready ignored (access 1)", strb, 1);
    run(1'b0, 4'd0, 4'd0, 4'd0, 24'h0000BB, 4'h2, '0, 0, '0, 0);
    chk(strb == 1 && tot == 1, "R8 ready ignored (access 0)", strb, 1);
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R9 rdata held through a write
    chk(rdata === 32'h3333_4444, "R9 last read kept", rdata, 32'h3333_4444);

    // R10 / R11: request and config change during an access are dropped
    run(1'b1, 4'd3, 4'd3, 4'd3, 24'h055555, 4'h9, 32'h1234_5678, 0, '0, 2);
    chk(strb == 3 && tot == 9, "R11 timing unchanged", tot, 9);
    begin
      int extra = 0;
      for (int k = 0; k < 4; k++) begin
        if (mem_sel) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R10 busy request dropped", extra, 0);
    end
    chk(rdata === 32'h3333_4444, "R9 rdata unchanged by write", rdata, 32'h3333_4444);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule